// File: doc/BRIEF.md
# Reference power-state controller

This block decides when the voltage reference and the reference buffer of an analog-to-digital converter are powered. A 2-bit power-down code is taken from the converter's command register (the field at bits 2 and 1 of that register, presented here as `pd_code[1:0]`). A new code takes effect when chip-select is released. The block then holds one of four power states until a wake event, a settling interval or the next release of chip-select moves it on.

The wake event depends on the interface mode. In the serial mode (`dsp_mode` = 0), asserting chip-select wakes the circuits. In the frame-based mode (`dsp_mode` = 1), an edge of the frame signal wakes them. Which frame edge counts depends on what was powered off. A wake from full shutdown brings the reference and buffer up at once, but it holds the ready flag low for `SETTLE_CYCLES` clock cycles, which stand in for the reference's settling time of several milliseconds.

The states are ACTIVE (reference and buffer on, ready), FULL_OFF (everything off), BUF_OFF (reference on, buffer off), EXT_REF (both off, external reference in use, ready) and SETTLE (both on, ready held low). The transitions are:
- latch: any state, on a chip-select release, goes to the state of the code.
- wake_full: FULL_OFF to SETTLE.
- wake_buf: BUF_OFF to ACTIVE.
- settle_done: SETTLE to ACTIVE.

Top module: `refpd_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the state is ACTIVE: `ref_en`=1, `buf_en`=1, `ref_ready`=1.
- R2: On a rising edge of `cs_n`, the code on `pd_code` is latched. From the next clock the outputs (`ref_en`,`buf_en`,`ref_ready`) are as follows: code 00 gives (1,1,1); code 01 gives (0,0,0); code 10 gives (1,0,1); code 11 gives (0,0,1).
- R3: Changes of `pd_code` without a rising edge of `cs_n` (while `cs_n` is low, or high and steady) do not change the outputs.
- R4: In FULL_OFF with `dsp_mode`=0, a falling edge of `cs_n` wakes the block. Edges of `frame` have no effect.
- R5: In FULL_OFF with `dsp_mode`=1, a falling edge of `frame` wakes the block. A falling edge of `cs_n` and a rising edge of `frame` have no effect.
- R6: In BUF_OFF, the wake event is a falling edge of `cs_n` when `dsp_mode`=0 and a rising edge of `frame` when `dsp_mode`=1. The wake sets `buf_en`=1 with no settling wait. A falling edge of `frame` in frame mode has no effect.
- R7: A wake from FULL_OFF sets `ref_en`=1 and `buf_en`=1 from the next clock. It holds `ref_ready`=0 for exactly `SETTLE_CYCLES` clocks, then sets it to 1.
- R8: EXT_REF has no wake event. The outputs stay at (0,0,1) whatever `frame` and the falling edges of `cs_n` do, until the next rising edge of `cs_n`.
- R9: A rising edge of `cs_n` with code 00 during SETTLE does not cut the wait short: `ref_ready` still rises at the original time. Any other code takes effect at once.
- R10: A rising edge of `cs_n` takes priority over a wake event in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cs_n | input | 1 | Chip-select, active low; its release latches the code |
| frame | input | 1 | Frame signal of the frame-based interface mode |
| dsp_mode | input | 1 | 1 selects the frame-based wake edges, 0 the serial ones |
| pd_code | input | 2 | Power-down code from the command register |
| ref_en | output | 1 | Internal reference powered |
| buf_en | output | 1 | Reference buffer powered |
| ref_ready | output | 1 | Reference valid for conversion |

## Verification
Directed sequences apply each code in turn. Each one is followed by the wrong wake edges and then the right one, in both interface modes, so a design that swaps the frame polarity between the two sleep states, or wakes on chip-select in frame mode, is caught. Further sequences move `pd_code` while chip-select is held low, release chip-select during the settling wait with code 00 and then with code 10, and count the exact number of low cycles of `ref_ready`; these separate a correct settle length from one that is one cycle off. A long run of seeded random edges on `cs_n`, `frame`, `dsp_mode` and `pd_code` is compared every cycle with a bench model built from the requirements. This reaches coincident edges, such as a release on the same cycle as a wake, that the directed cases do not.

// File: rtl/refpd_pkg.sv
package refpd_pkg;

    typedef enum logic [2:0] {
        ST_ACTIVE   = 3'd0,
        ST_FULL_OFF = 3'd1,
        ST_BUF_OFF  = 3'd2,
        ST_EXT_REF  = 3'd3,
        ST_SETTLE   = 3'd4
    } refpd_state_e;

    localparam int unsigned PD_CODE_W = 2;

    localparam logic [PD_CODE_W-1:0] PD_KEEP = 2'b00;
    localparam logic [PD_CODE_W-1:0] PD_FULL = 2'b01;
    localparam logic [PD_CODE_W-1:0] PD_BUF  = 2'b10;
    localparam logic [PD_CODE_W-1:0] PD_EXT  = 2'b11;

endpackage

// File: rtl/refpd_edge.sv
module refpd_edge #(
    parameter bit IDLE_LEVEL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise,
    output logic fall
);

    logic prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= IDLE_LEVEL;
        end else begin
            prev_q <= din;
        end
    end

    assign rise = din & ~prev_q;
    assign fall = ~din & prev_q;

endmodule

// File: rtl/refpd_settle.sv
module refpd_settle #(
    parameter int unsigned SETTLE_CYCLES = 625000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic expire
);

    localparam int unsigned CNT_W = $clog2(SETTLE_CYCLES + 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= CNT_W'(SETTLE_CYCLES);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign expire = (cnt_q == CNT_W'(1));

    // R7
    cnt_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

endmodule

// File: rtl/refpd_ctrl.sv
module refpd_ctrl #(
    parameter int unsigned SETTLE_CYCLES = 625000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic       frame,
    input  logic       dsp_mode,
    input  logic [1:0] pd_code,
    output logic       ref_en,
    output logic       buf_en,
    output logic       ref_ready
);

    import refpd_pkg::*;

    refpd_state_e state_q, state_d;

    logic cs_rise, cs_fall;
    logic fr_rise, fr_fall;
    logic wake_full, wake_buf;
    logic tmr_start, tmr_expire;

    refpd_edge #(.IDLE_LEVEL(1'b1)) cs_edge_i (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (cs_n),
        .rise (cs_rise),
        .fall (cs_fall)
    );

    refpd_edge #(.IDLE_LEVEL(1'b0)) fr_edge_i (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (frame),
        .rise (fr_rise),
        .fall (fr_fall)
    );

    refpd_settle #(.SETTLE_CYCLES(SETTLE_CYCLES)) settle_i (
        .clk   (clk),
        .rst_n (rst_n),
        .start (tmr_start),
        .expire(tmr_expire)
    );

    assign wake_full = dsp_mode ? fr_fall : cs_fall;
    assign wake_buf  = dsp_mode ? fr_rise : cs_fall;

    // next state
    always_comb begin
        state_d   = state_q;
        tmr_start = 1'b0;
        if (cs_rise) begin
            unique case (pd_code)
                PD_KEEP: begin
                    if (state_q == ST_SETTLE && !tmr_expire) begin
                        state_d = ST_SETTLE;
                    end else begin
                        state_d = ST_ACTIVE;
                    end
                end
                PD_FULL: state_d = ST_FULL_OFF;
                PD_BUF:  state_d = ST_BUF_OFF;
                PD_EXT:  state_d = ST_EXT_REF;
                default: state_d = ST_ACTIVE;
            endcase
        end else begin
            unique case (state_q)
                ST_ACTIVE: begin
                    state_d = ST_ACTIVE;
                end
                ST_EXT_REF: begin
                    state_d = ST_EXT_REF;
                end
                ST_FULL_OFF: begin
                    if (wake_full) begin
                        state_d   = ST_SETTLE;
                        tmr_start = 1'b1;
                    end
                end
                ST_BUF_OFF: begin
                    if (wake_buf) begin
                        state_d = ST_ACTIVE;
                    end
                end
                ST_SETTLE: begin
                    if (tmr_expire) begin
                        state_d = ST_ACTIVE;
                    end
                end
                default: state_d = ST_ACTIVE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_ACTIVE;
        end else begin
            state_q <= state_d;
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ST_ACTIVE:   begin ref_en = 1'b1; buf_en = 1'b1; ref_ready = 1'b1; end
            ST_FULL_OFF: begin ref_en = 1'b0; buf_en = 1'b0; ref_ready = 1'b0; end
            ST_BUF_OFF:  begin ref_en = 1'b1; buf_en = 1'b0; ref_ready = 1'b1; end
            ST_EXT_REF:  begin ref_en = 1'b0; buf_en = 1'b0; ref_ready = 1'b1; end
            ST_SETTLE:   begin ref_en = 1'b1; buf_en = 1'b1; ref_ready = 1'b0; end
            default:     begin ref_en = 1'b1; buf_en = 1'b1; ref_ready = 1'b1; end
        endcase
    end

    // R2
    buf_needs_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
        buf_en |-> ref_en);

    // R2
    full_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_rise && pd_code == PD_FULL) |=> (!ref_en && !buf_en && !ref_ready));

    // R3
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_rise && (state_q == ST_ACTIVE || state_q == ST_EXT_REF)) |=> $stable(state_q));

    // R7
    wake_settle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FULL_OFF && wake_full && !cs_rise) |=> (ref_en && buf_en && !ref_ready));

    // R6
    buf_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BUF_OFF && wake_buf && !cs_rise) |=> (buf_en && ref_ready));

    // R9
    settle_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SETTLE && !tmr_expire && (!cs_rise || pd_code == PD_KEEP))
        |=> (state_q == ST_SETTLE));

endmodule

// File: tb/refpd_ctrl_tb_top.sv
module refpd_ctrl_tb_top;

    localparam int unsigned N = 6;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cs_n;
    logic       frame;
    logic       dsp_mode;
    logic [1:0] pd_code;
    logic       ref_en, buf_en, ref_ready;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    // bench model: 0 active, 1 full off, 2 buf off, 3 ext ref, 4 settling
    int m_st;
    int m_left;
    bit m_pcs;
    bit m_pfr;

    always #4 clk = ~clk;

    refpd_ctrl #(.SETTLE_CYCLES(N)) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n     (cs_n),
        .frame    (frame),
        .dsp_mode (dsp_mode),
        .pd_code  (pd_code),
        .ref_en   (ref_en),
        .buf_en   (buf_en),
        .ref_ready(ref_ready)
    );

    function automatic logic [2:0] exp_out(input int st);
        case (st)
            0: return 3'b111;
            1: return 3'b000;
            2: return 3'b101;
            3: return 3'b001;
            default: return 3'b110;
        endcase
    endfunction

    task automatic model_adv(input bit c, input bit f, input bit d, input logic [1:0] k);
        bit rise, cfall, frise, ffall;
        rise  = c && !m_pcs;
        cfall = !c && m_pcs;
        frise = f && !m_pfr;
        ffall = !f && m_pfr;
        if (m_st == 4 && !(rise && k != 2'b00)) begin
            if (m_left == 1) m_st = 0;
            else m_left = m_left - 1;
        end else if (rise) begin
            m_st = int'(k);
            if (k == 2'b00) m_st = 0;
        end else if (m_st == 1) begin
            if (d ? ffall : cfall) begin m_st = 4; m_left = N; end
        end else if (m_st == 2) begin
            if (d ? frise : cfall) m_st = 0;
        end
        m_pcs = c;
        m_pfr = f;
    endtask

    task automatic check(input string tag, input logic [2:0] exp);
        logic [2:0] act;
        act = {ref_en, buf_en, ref_ready};
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b (ref,buf,ready) t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(input string tag, input bit c, input bit f, input bit d, input logic [1:0] k);
        cs_n = c; frame = f; dsp_mode = d; pd_code = k;
        model_adv(c, f, d, k);
        @(posedge clk);
        @(negedge clk);
        check(tag, exp_out(m_st));
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL WDOG all actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0A17));
        rst_n = 1'b0; cs_n = 1'b1; frame = 1'b0; dsp_mode = 1'b0; pd_code = 2'b00;
        m_st = 0; m_left = 0; m_pcs = 1'b1; m_pfr = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 reset", 3'b111);
        rst_n = 1'b1;

        // SPI full shutdown: frame edges ignored, cs fall wakes, exact settle
        step("R3 code change cs high steady", 1, 0, 0, 2'b01);
        check("R3 no latch without edge", 3'b111);
        step("R2 cs low", 0, 0, 0, 2'b01);
        step("R2 latch 01", 1, 0, 0, 2'b01);
        check("R2 code01", 3'b000);
        step("R4 frame rise", 1, 1, 0, 2'b00);
        step("R4 frame fall", 1, 0, 0, 2'b11);
        check("R4 frame ignored", 3'b000);
        step("R7 cs fall wakes", 0, 0, 0, 2'b00);
        check("R7 on not ready", 3'b110);
        for (int i = 1; i < N; i++) step("R7 settle low", 0, 0, 0, 2'b00);
        check("R7 last low cycle", 3'b110);
        step("R7 ready", 0, 0, 0, 2'b00);
        check("R7 ready after N", 3'b111);

        // R3: field moves while cs low
        step("R3 code 11 cs low", 0, 0, 0, 2'b11);
        step("R3 code 01 cs low", 0, 0, 0, 2'b01);
        check("R3 cs low no effect", 3'b111);

        // buffer-off, SPI wake
        step("R2 latch 10", 1, 0, 0, 2'b10);
        check("R2 code10", 3'b101);
        step("R6 spi cs fall", 0, 0, 0, 2'b10);
        check("R6 spi buf wake", 3'b111);

        // buffer-off, DSP wake on frame rise only
        step("R2 latch 10 dsp", 1, 0, 1, 2'b10);
        step("R6 dsp cs fall ignored", 0, 0, 1, 2'b10);
        check("R6 dsp cs fall ignored", 3'b101);
        step("R6 frame rise", 0, 1, 1, 2'b10);
        check("R6 dsp frame rise wakes", 3'b111);
        step("R6 cs release 10", 1, 1, 1, 2'b10);
        step("R6 frame fall ignored", 1, 0, 1, 2'b10);
        check("R6 frame fall ignored", 3'b101);
        step("R6 frame rise 2", 1, 1, 1, 2'b10);
        check("R6 frame rise wakes 2", 3'b111);

        // full-off, DSP wake on frame fall only
        step("R5 cs low", 0, 1, 1, 2'b01);
        step("R2 latch 01 dsp", 1, 0, 1, 2'b01);
        step("R5 frame rise ignored", 1, 1, 1, 2'b01);
        step("R5 cs fall ignored", 0, 1, 1, 2'b01);
        check("R5 wrong edges ignored", 3'b000);
        step("R5 frame fall wakes", 0, 0, 1, 2'b01);
        check("R5 frame fall wake", 3'b110);

        // R9: code 00 release mid-settle keeps the wait
        step("R9 settle 2", 0, 0, 1, 2'b00);
        step("R9 release 00", 1, 0, 1, 2'b00);
        check("R9 still settling", 3'b110);
        for (int i = 3; i < N; i++) step("R9 settle cont", 1, 0, 1, 2'b00);
        check("R9 last low", 3'b110);
        step("R9 ready on time", 1, 0, 1, 2'b00);
        check("R9 ready on time", 3'b111);

        // R9: other code mid-settle takes effect at once
        step("R9 cs low", 0, 0, 0, 2'b01);
        step("R9 latch 01", 1, 0, 0, 2'b01);
        step("R9 wake", 0, 0, 0, 2'b01);
        step("R9 release 10", 1, 0, 0, 2'b10);
        check("R9 code10 in settle", 3'b101);

        // R8: external reference ignores all wake edges
        step("R8 cs low", 0, 0, 0, 2'b11);
        step("R8 latch 11", 1, 0, 0, 2'b11);
        check("R2 code11", 3'b001);
        step("R8 cs fall", 0, 1, 0, 2'b11);
        step("R8 frame fall", 0, 0, 1, 2'b11);
        step("R8 frame rise", 0, 1, 1, 2'b11);
        check("R8 ext ref held", 3'b001);

        // R10: release and wake in the same cycle
        step("R10 latch 01", 1, 1, 1, 2'b01);
        step("R10 release with frame fall", 0, 1, 1, 2'b01);
        step("R10 coincident", 1, 0, 1, 2'b10);
        check("R10 release wins", 3'b101);

        // random
        for (int i = 0; i < 3000; i++) begin
            bit c, f, d;
            logic [1:0] k;
            c = ($urandom_range(0, 3) != 0) ? cs_n : ~cs_n;
            f = ($urandom_range(0, 2) != 0) ? frame : ~frame;
            d = ($urandom_range(0, 40) == 0) ? ~dsp_mode : dsp_mode;
            k = 2'($urandom_range(0, 3));
            step("RND R2 R4 R5 R6 R7 R8 R9 R10", c, f, d, k);
        end

        done = 1'b1;
        summary();
        $finish;
    end

endmodule